// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block watches a set of exception request lines together with the processor's current status word. On each clock edge it picks the most urgent request that is not masked. In the following cycle it presents, as one coherent record, everything the core needs to enter that exception: a take strobe, the target mode number, the rewritten status word, the copy of the old status word for the banked saved-status register, the return link address and the vector PC. The record is registered, so the core can commit all of it in the cycle the strobe is high.

The block has three states. `ST_BOOT` is held while the asynchronous reset `rst_n` is low. `ST_IDLE` means no entry is being presented. `ST_TAKE` presents an entry record with `take` high. The transitions are:
- **boot-entry**: `ST_BOOT` to `ST_TAKE` on the first edge after reset is released. This emits the reset entry.
- **accept**: `ST_IDLE` to `ST_TAKE` when an unmasked request is present at an edge.
- **chain**: `ST_TAKE` to `ST_TAKE` when another unmasked request is present.
- **retire**: `ST_TAKE` to `ST_IDLE` when no unmasked request is present.

The status word layout follows the usual fields:
- bits [4:0] hold the mode.
- bit 5 selects the compact instruction state.
- bit 6 disables the fast interrupt.
- bit 7 disables the interrupt.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several requests are present at once, the winner is taken in this order, highest first: sync reset, data abort, fast interrupt, interrupt, prefetch abort, and then undefined and software interrupt at the lowest level.
- R2: When undefined and software interrupt are both requested, undefined is taken.
- R3: For every entry except reset, `new_status` keeps `cur_status[31:8]`, has bit 5 cleared and carries the target mode in bits [4:0]. `saved_status` equals the sampled `cur_status`.
- R4: Bit 7 of `new_status` is set on every entry. Bit 6 is set on reset and fast-interrupt entry; on any other entry it keeps `cur_status[6]`.
- R5: An interrupt request is ignored while `cur_status[7]` is 1, and a fast interrupt request is ignored while `cur_status[6]` is 1. A masked request lets the next request in priority order win, and yields no take if no other request is present. Aborts, undefined and software interrupt are never masked.
- R6: The target mode numbers are:
  - supervisor 5'b10011 for reset and software interrupt
  - abort 5'b10111 for both aborts
  - interrupt 5'b10010
  - fast interrupt 5'b10001
  - undefined 5'b11011
- R7: `vec_pc` is the base OR'd with an offset. The base is 0x00000000 when `hi_vec` is 0 and 0xFFFF0000 when it is 1. The offsets are:
  - reset 0x00
  - undefined 0x04
  - software interrupt 0x08
  - prefetch abort 0x0C
  - data abort 0x10
  - interrupt 0x18
  - fast interrupt 0x1C
- R8: `link_addr` is `inst_addr`+8 for data abort and `inst_addr`+4 for every other non-reset entry.
- R9: Requests are sampled at a rising edge. `take` and the record are valid during the next cycle only. With no unmasked request at an edge, `take` is 0 in the next cycle.
- R10: While `rst_n` is low, `take` is 0, `tgt_mode` is 5'b10011, `new_status` is 0x000000D3 and `vec_pc` is 0. The first edge after release, and any edge with `req_reset` high, yields a reset entry. That entry has `new_status` 0x000000D3, mode 5'b10011 and the vector chosen by `hi_vec`; its link and saved-status values are don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Synchronous reset-entry request |
| req_dabort | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_status | input | 32 | Current status word |
| inst_addr | input | ADDR_W | Address of the faulting or current instruction |
| hi_vec | input | 1 | High vector base select |
| take | output | 1 | Entry strobe, one cycle per entry |
| tgt_mode | output | 5 | Target mode number |
| new_status | output | 32 | Status word to install |
| saved_status | output | 32 | Value for the banked saved-status register |
| link_addr | output | ADDR_W | Return link value |
| vec_pc | output | ADDR_W | Vector address |

## Verification
Every result is due exactly one cycle after the edge that samples the request: the take strobe, the mode, both status words, the link and the vector all appear together. The bench drives each stimulus at a falling edge, lets one rising edge pass, and checks all fields at the next falling edge, before the next stimulus is applied. For the reset entry, the record is checked at the falling edge after the first rising edge following release. The reset values themselves are checked while `rst_n` is still low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int NUM_EXC = 7;
    localparam int STAT_W  = 32;

    // Enumeration order is priority order: lower value wins.
    typedef enum logic [2:0] {
        EX_RESET = 3'd0,
        EX_DABT  = 3'd1,
        EX_FIQ   = 3'd2,
        EX_IRQ   = 3'd3,
        EX_PABT  = 3'd4,
        EX_UNDEF = 3'd5,
        EX_SWI   = 3'd6
    } exc_kind_t;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_TAKE = 2'd2
    } entry_state_t;

    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_UND = 5'b11011;

    function automatic logic [4:0] mode_of(exc_kind_t k);
        logic [4:0] m;
        unique case (k)
            EX_RESET, EX_SWI: m = MODE_SVC;
            EX_DABT, EX_PABT: m = MODE_ABT;
            EX_FIQ:           m = MODE_FIQ;
            EX_IRQ:           m = MODE_IRQ;
            default:          m = MODE_UND;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] vec_off(exc_kind_t k);
        logic [7:0] o;
        unique case (k)
            EX_RESET: o = 8'h00;
            EX_UNDEF: o = 8'h04;
            EX_SWI:   o = 8'h08;
            EX_PABT:  o = 8'h0C;
            EX_DABT:  o = 8'h10;
            EX_IRQ:   o = 8'h18;
            default:  o = 8'h1C;
        endcase
        return o;
    endfunction

    function automatic logic [3:0] link_off(exc_kind_t k);
        logic [3:0] o;
        unique case (k)
            EX_RESET: o = 4'd0;
            EX_DABT:  o = 4'd8;
            default:  o = 4'd4;
        endcase
        return o;
    endfunction

    function automatic logic sets_fdis(exc_kind_t k);
        return (k == EX_RESET) || (k == EX_FIQ);
    endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick
    import exc_entry_pkg::*;
#(
    parameter int NUM = NUM_EXC
) (
    input  logic [NUM-1:0] req,
    input  logic           i_dis,
    input  logic           f_dis,
    output logic           valid,
    output exc_kind_t      kind
);

    logic [NUM-1:0] live;

    always_comb begin
        live = req;
        live[EX_IRQ] = req[EX_IRQ] & ~i_dis;
        live[EX_FIQ] = req[EX_FIQ] & ~f_dis;
    end

    always_comb begin
        valid = |live;
        kind  = EX_RESET;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (live[i]) begin
                kind = exc_kind_t'(3'(i));
            end
        end
    end

endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_entry_pkg::*;
#(
    parameter int              ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  exc_kind_t         kind,
    input  logic [STAT_W-1:0] cur_status,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic              hi_vec,
    output logic [4:0]        mode,
    output logic [STAT_W-1:0] status_nxt,
    output logic [STAT_W-1:0] spsr,
    output logic [ADDR_W-1:0] link,
    output logic [ADDR_W-1:0] vec
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        mode = mode_of(kind);
        base = hi_vec ? HI_BASE : '0;
        vec  = base | ADDR_W'(vec_off(kind));
        if (kind == EX_RESET) begin
            status_nxt = {{(STAT_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, mode};
            spsr       = '0;
            link       = '0;
        end else begin
            status_nxt = {cur_status[STAT_W-1:8], 1'b1,
                          sets_fdis(kind) | cur_status[6], 1'b0, mode};
            spsr       = cur_status;
            link       = inst_addr + ADDR_W'(link_off(kind));
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_dabort,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabort,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic [31:0]       cur_status,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic              hi_vec,
    output logic              take,
    output logic [4:0]        tgt_mode,
    output logic [31:0]       new_status,
    output logic [31:0]       saved_status,
    output logic [ADDR_W-1:0] link_addr,
    output logic [ADDR_W-1:0] vec_pc
);

    localparam logic [STAT_W-1:0] BOOT_STATUS = {{(STAT_W-8){1'b0}}, 8'hD3};

    entry_state_t      state, nxt;
    logic [NUM_EXC-1:0] req_vec;
    logic              win_valid;
    exc_kind_t         win_kind, sel_kind;
    logic [4:0]        f_mode;
    logic [STAT_W-1:0] f_status, f_spsr;
    logic [ADDR_W-1:0] f_link, f_vec;

    assign req_vec = {req_swi, req_undef, req_pabort, req_irq,
                      req_fiq, req_dabort, req_reset};

    exc_pick #(.NUM(NUM_EXC)) u_pick (
        .req   (req_vec),
        .i_dis (cur_status[7]),
        .f_dis (cur_status[6]),
        .valid (win_valid),
        .kind  (win_kind)
    );

    assign sel_kind = (state == ST_BOOT) ? EX_RESET : win_kind;

    exc_frame #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_frame (
        .kind       (sel_kind),
        .cur_status (cur_status),
        .inst_addr  (inst_addr),
        .hi_vec     (hi_vec),
        .mode       (f_mode),
        .status_nxt (f_status),
        .spsr       (f_spsr),
        .link       (f_link),
        .vec        (f_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT: nxt = ST_TAKE;                            // boot-entry
            ST_IDLE: nxt = win_valid ? ST_TAKE : ST_IDLE;      // accept
            ST_TAKE: nxt = win_valid ? ST_TAKE : ST_IDLE;      // chain / retire
            default: nxt = ST_IDLE;
        endcase
    end

    // Output record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_mode     <= MODE_SVC;
            new_status   <= BOOT_STATUS;
            saved_status <= '0;
            link_addr    <= '0;
            vec_pc       <= '0;
        end else if (nxt == ST_TAKE) begin
            tgt_mode     <= f_mode;
            new_status   <= f_status;
            saved_status <= f_spsr;
            link_addr    <= f_link;
            vec_pc       <= f_vec;
        end
    end

    assign take = (state == ST_TAKE);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take && tgt_mode == MODE_IRQ |-> !$past(cur_status[7]));          // R5
    AST_FIQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take && tgt_mode == MODE_FIQ |-> !$past(cur_status[6]) && new_status[6]); // R5
    AST_MODE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !new_status[5] && new_status[4:0] == tgt_mode);          // R3
    AST_IDIS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> new_status[7]);                                          // R4
    AST_ABT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take && tgt_mode == MODE_ABT |-> saved_status == $past(cur_status)); // R3

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    typedef struct packed {
        logic [6:0]  req;    // [6]reset [5]dabt [4]fiq [3]irq [2]pabt [1]undef [0]swi
        logic [31:0] st;
        logic [31:0] addr;
        logic        hv;
        logic        etake;
        logic [4:0]  emode;
        logic [31:0] evec;
        logic [31:0] elink;
    } row_t;

    localparam int NROW = 15;
    localparam row_t TBL [NROW] = '{
        '{7'b0000000, 32'h6000_0010, 32'h0000_1000, 1'b0, 1'b0, 5'h00, 32'h0,         32'h0},
        '{7'b0000001, 32'h6000_0030, 32'h0000_1000, 1'b0, 1'b1, 5'h13, 32'h08,        32'h1004},
        '{7'b0000011, 32'h6000_0010, 32'h0000_2000, 1'b0, 1'b1, 5'h1B, 32'h04,        32'h2004},
        '{7'b0000110, 32'h6000_0010, 32'h0000_3000, 1'b1, 1'b1, 5'h17, 32'hFFFF_000C, 32'h3004},
        '{7'b0001100, 32'h6000_0010, 32'h0000_4000, 1'b0, 1'b1, 5'h12, 32'h18,        32'h4004},
        '{7'b0011000, 32'h6000_0010, 32'h0000_5000, 1'b1, 1'b1, 5'h11, 32'hFFFF_001C, 32'h5004},
        '{7'b0110000, 32'h6000_0010, 32'h0000_6000, 1'b0, 1'b1, 5'h17, 32'h10,        32'h6008},
        '{7'b1100000, 32'h6000_0010, 32'h0000_7000, 1'b0, 1'b1, 5'h13, 32'h00,        32'h0},
        '{7'b0001000, 32'h6000_0090, 32'h0000_8000, 1'b0, 1'b0, 5'h00, 32'h0,         32'h0},
        '{7'b0001100, 32'h6000_0090, 32'h0000_9000, 1'b0, 1'b1, 5'h17, 32'h0C,        32'h9004},
        '{7'b0010000, 32'h6000_0050, 32'h0000_A000, 1'b0, 1'b0, 5'h00, 32'h0,         32'h0},
        '{7'b0011000, 32'h6000_0050, 32'h0000_B000, 1'b0, 1'b1, 5'h12, 32'h18,        32'hB004},
        '{7'b0100000, 32'h6000_00D0, 32'h0000_C000, 1'b1, 1'b1, 5'h17, 32'hFFFF_0010, 32'hC008},
        '{7'b0010000, 32'h6000_0090, 32'h0000_D000, 1'b0, 1'b1, 5'h11, 32'h1C,        32'hD004},
        '{7'b0000010, 32'h6000_0010, 32'h0000_FFFC, 1'b1, 1'b1, 5'h1B, 32'hFFFF_0004, 32'h1_0000}
    };

    localparam string TAG [NROW] = '{
        "R9 no request", "R6 swi", "R2 undef over swi", "R1 pabt over undef",
        "R1 irq over pabt", "R1 fiq over irq", "R1 dabt over fiq", "R1 reset over dabt",
        "R5 irq masked", "R5 masked irq yields pabt", "R5 fiq masked",
        "R5 masked fiq yields irq", "R5 dabt unmasked", "R4 fiq sets bit6", "R8 undef link"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_dabort = 0, req_fiq = 0, req_irq = 0;
    logic        req_pabort = 0, req_undef = 0, req_swi = 0;
    logic [31:0] cur_status = '0;
    logic [31:0] inst_addr = '0;
    logic        hi_vec = 1'b0;
    logic        take;
    logic [4:0]  tgt_mode;
    logic [31:0] new_status, saved_status, link_addr, vec_pc;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk, .rst_n, .req_reset, .req_dabort, .req_fiq, .req_irq,
        .req_pabort, .req_undef, .req_swi, .cur_status, .inst_addr, .hi_vec,
        .take, .tgt_mode, .new_status, .saved_status, .link_addr, .vec_pc
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic drive(input logic [6:0] r, input logic [31:0] st,
                         input logic [31:0] a, input logic hv);
        {req_reset, req_dabort, req_fiq, req_irq, req_pabort, req_undef, req_swi} = r;
        cur_status = st;
        inst_addr  = a;
        hi_vec     = hv;
    endtask

    function automatic logic [31:0] model_status(input logic [31:0] st,
                                                 input logic [4:0] m, input logic rst);
        if (rst) return 32'h0000_00D3;
        return {st[31:8], 1'b1, (m == 5'h11) ? 1'b1 : st[6], 1'b0, m};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: values held during reset
        drive(7'b0, 32'h0, 32'h0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 take in reset", {31'b0, take}, 32'h0);
        chk("R10 mode in reset", {27'b0, tgt_mode}, 32'h13);
        chk("R10 status in reset", new_status, 32'h0000_00D3);
        chk("R10 vector in reset", vec_pc, 32'h0);

        // R10: boot entry on first edge after release, high vectors
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 boot take", {31'b0, take}, 32'h1);
        chk("R10 boot mode", {27'b0, tgt_mode}, 32'h13);
        chk("R10 boot status", new_status, 32'h0000_00D3);
        chk("R10 boot vector", vec_pc, 32'hFFFF_0000);
        @(negedge clk);
        chk("R9 retire after boot", {31'b0, take}, 32'h0);

        // Table walk
        for (int i = 0; i < NROW; i++) begin
            logic [4:0] m;
            drive(TBL[i].req, TBL[i].st, TBL[i].addr, TBL[i].hv);
            @(negedge clk);
            m = TBL[i].emode;
            chk({TAG[i], " R9 take"}, {31'b0, take}, {31'b0, TBL[i].etake});
            if (TBL[i].etake) begin
                chk({TAG[i], " R6 mode"}, {27'b0, tgt_mode}, {27'b0, m});
                chk({TAG[i], " R7 vector"}, vec_pc, TBL[i].evec);
                chk({TAG[i], " R3 R4 status"}, new_status,
                    model_status(TBL[i].st, m, TBL[i].req[6]));
                if (!TBL[i].req[6]) begin
                    chk({TAG[i], " R8 link"}, link_addr, TBL[i].elink);
                    chk({TAG[i], " R3 spsr"}, saved_status, TBL[i].st);
                end
            end
        end

        // R9: single-cycle strobe for a one-cycle request
        drive(7'b0001000, 32'h0000_0010, 32'h100, 1'b0);
        @(negedge clk);
        drive(7'b0, 32'h0000_0010, 32'h100, 1'b0);
        chk("R9 strobe high", {31'b0, take}, 32'h1);
        @(negedge clk);
        chk("R9 strobe dropped", {31'b0, take}, 32'h0);

        // R10: sync reset request ignores old status, low vector
        drive(7'b1000001, 32'hFFFF_FF3F, 32'h200, 1'b0);
        @(negedge clk);
        drive(7'b0, 32'h0, 32'h0, 1'b0);
        chk("R10 sync reset status", new_status, 32'h0000_00D3);
        chk("R10 sync reset vector", vec_pc, 32'h0);
        chk("R10 sync reset mode", {27'b0, tgt_mode}, 32'h13);

        // R10: async reset mid-run returns to reset values
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 async take", {31'b0, take}, 32'h0);
        chk("R10 async status", new_status, 32'h0000_00D3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule